// File: doc/BRIEF.md
# Programmable Beep Tone Generator

This block turns a low-speed clock of about 128 kHz into a square-wave tone that is audible. Software sets the tone through one 8-bit control register on a byte-wide bus. The bus has an address, a write strobe, write data and combinational read data. The register has three fields:

- a 5-bit prescaler code;
- an enable bit;
- a 2-bit tone select.

The clock passes through two dividers in series. The first is a programmable prescaler that divides by the code plus two. The second is a final stage that divides by 8, 4 or 2 and shapes the result into a square wave with a 50% duty cycle. With a nominal 128 kHz clock, the intended outputs are 1, 2 or 4 kHz.

The bus and the dividers both run on the low-speed clock. The register value that software sees is kept apart from the settings that the dividers are using. While a tone is playing, the register is copied into the active settings only at a prescaler terminal count. A new setting therefore takes hold at a period boundary and never shortens a half-period.

The reset value holds code 0x1F. That code is not a legal setting, so the output stays silent until software programs a valid code.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the register reads 0x1F and the tone output is low.
- R2: The register sits at address 0. Bits 7:6 are the tone select, bit 5 is the enable and bits 4:0 are the prescaler code. A read returns exactly the last value written. Reads at any other address return 0, and writes to any other address leave the register unchanged.
- R3: A prescaler code N divides the clock by N+2. Code 0 divides by 2 and code 0x1E divides by 32.
- R4: Tone select 00 adds a final divide by 8, select 01 a divide by 4, and select 10 or 11 a divide by 2. Every high and every low stretch of the output lasts (N+2)×final/2 clock cycles.
- R5: While the block is disabled, the output is low and both divider counters are cleared. After an enabling write from the idle state, the output first rises 1+(N+2)×final/2 cycles after the clock edge that captured the write.
- R6: With code 0x1F the output stays low even when the enable bit is 1.
- R7: While a tone is running, a write takes effect at the next prescaler terminal count. A write captured on the same edge as a terminal count takes effect at the terminal count after that one.
- R8: A write that clears the enable bit while a tone is running drives the output low at the terminal count that applies it. The output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock, about 128 kHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tone_o | output | 1 | Square-wave tone output |

## Verification
A register write and a prescaler terminal count can fall in the same cycle. In that cycle the active settings are reloaded from the register value as it stood before the write.

The bench provokes this case with a running tone whose final divide is 2, so the output toggles on every terminal count. It watches for a rising edge of the output and then times a write to be captured exactly one prescaler period later. It judges the result from the lengths of the next three output stretches: two at the old length, then the new length. If the new value were applied one terminal count early, the first stretch would come out at the new length.

// File: rtl/beep_pkg.sv
package beep_pkg;

  localparam int CODE_W = 5;
  localparam int SEL_W  = 2;
  localparam int PCNT_W = CODE_W + 1;
  localparam int FCNT_W = 2;

  localparam logic [CODE_W-1:0] CODE_BAD  = '1;
  localparam logic [7:0]        CFG_RESET = 8'h1F;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              en;
    logic [CODE_W-1:0] code;
  } beep_cfg_t;

  // prescaler divide factor: code plus two
  function automatic logic [PCNT_W-1:0] pre_factor(input logic [CODE_W-1:0] code);
    return {1'b0, code} + PCNT_W'(2);
  endfunction

  // number of prescaler ticks per output half-period
  function automatic logic [2:0] half_ticks(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // a setting that produces a tone
  function automatic logic cfg_runs(input beep_cfg_t c);
    return c.en && (c.code != CODE_BAD);
  endfunction

endpackage

// File: rtl/beep_cfg_regs.sv
module beep_cfg_regs
  import beep_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CSR_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  output beep_cfg_t         act_cfg_o,
  output logic              run_o,
  output logic              stop_o
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CSR_ADDR);

  logic      hit;
  logic      csr_we;
  logic      load;
  beep_cfg_t csr_q;
  beep_cfg_t act_q;

  assign hit    = (addr_i == SEL_ADDR);
  assign csr_we = wr_i && hit;

  // software-visible register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= beep_cfg_t'(CFG_RESET);
    else if (csr_we) csr_q <= beep_cfg_t'(wdata_i);
  end

  assign rdata_o = hit ? csr_q : 8'h00;

  // active settings: follow the register while idle, else only at terminal count
  assign run_o  = cfg_runs(act_q);
  assign load   = !run_o || tick_i;
  assign stop_o = run_o && tick_i && !cfg_runs(csr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= beep_cfg_t'(CFG_RESET);
    else if (load) act_q <= csr_q;
  end

  assign act_cfg_o = act_q;

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (rdata_o == $past(wdata_i)) || !hit);

  p_active_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !tick_i) |=> (act_cfg_o == $past(act_cfg_o)));

endmodule

// File: rtl/beep_prescaler.sv
module beep_prescaler
  import beep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] factor;

  assign factor = pre_factor(code_i);
  assign tick_o = run_i && (pcnt_q == factor - PCNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + PCNT_W'(1);
  end

  p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pcnt_q < factor));

  p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pcnt_q == '0));

endmodule

// File: rtl/beep_final_stage.sv
module beep_final_stage
  import beep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tone_o
);

  logic [FCNT_W-1:0] fcnt_q;
  logic              tone_q;
  logic [2:0]        half;
  logic              flip;

  assign half = half_ticks(sel_i);
  // ">=" keeps a shrink of the half-period from stranding the counter
  assign flip = tick_i && ({1'b0, fcnt_q} >= (half - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      tone_q <= 1'b0;
    end else if (!run_i || stop_i) begin
      fcnt_q <= '0;
      tone_q <= 1'b0;
    end else if (flip) begin
      fcnt_q <= '0;
      tone_q <= !tone_q;
    end else if (tick_i) begin
      fcnt_q <= fcnt_q + FCNT_W'(1);
    end
  end

  assign tone_o = tone_q;

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tone_o);

  p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(tone_o) || !run_i);

  p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !tone_o);

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
  import beep_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CSR_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tone_o
);

  beep_cfg_t act_cfg;
  logic      run;
  logic      stop;
  logic      tick;

  beep_cfg_regs #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (bus_addr),
    .wr_i      (bus_wr),
    .wdata_i   (bus_wdata),
    .rdata_o   (bus_rdata),
    .tick_i    (tick),
    .act_cfg_o (act_cfg),
    .run_o     (run),
    .stop_o    (stop)
  );

  beep_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .code_i (act_cfg.code),
    .tick_o (tick)
  );

  beep_final_stage u_fin (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .stop_i (stop),
    .tick_i (tick),
    .sel_i  (act_cfg.sel),
    .tone_o (tone_o)
  );

  p_bad_code_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.code == CODE_BAD) |-> !tone_o);

endmodule

// File: tb/test_beep_tone_gen.sv
module test_beep_tone_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tone_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  beep_tone_gen i_beep_tone_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tone_o    (tone_o)
  );

  // {sel, code, expected half-period in cycles}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 5'h00, 16'd8},
    {2'b10, 5'h1E, 16'd32},
    {2'b01, 5'h0E, 16'd32},
    {2'b11, 5'h05, 16'd7},
    {2'b00, 5'h1D, 16'd124},
    {2'b01, 5'h01, 16'd6}
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_addr  = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = '0;
  endtask

  // count negedges while the output stays at the given level
  task automatic stretch(input logic lvl, output int n);
    n = 0;
    while (tone_o == lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    int hi_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_read(2'd0, rd);
    chk("R1", rd, 8'h1F, "reset register value");
    chk("R1", tone_o, 0, "reset output");

    // R2: readback with every field populated while disabled
    bus_write(2'd0, 8'hDA);
    bus_read(2'd0, rd);
    chk("R2", rd, 8'hDA, "readback");
    bus_write(2'd1, 8'h55);
    bus_read(2'd0, rd);
    chk("R2", rd, 8'hDA, "other-address write ignored");
    bus_read(2'd2, rd);
    chk("R2", rd, 0, "other-address read");
    chk("R5", tone_o, 0, "disabled output");

    // R3/R4/R5: vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] s;
      logic [4:0] c;
      int h;
      s = VEC[i][22:21];
      c = VEC[i][20:16];
      h = int'(VEC[i][15:0]);
      bus_write(2'd0, 8'h00);
      repeat (140) @(negedge clk);
      chk("R8", tone_o, 0, "low after disable");
      bus_write(2'd0, {s, 1'b1, c});
      stretch(1'b0, n);
      chk("R5", n, h + 1, "first edge latency");
      stretch(1'b1, n);
      chk("R4", n, h, "high stretch");
      stretch(1'b0, n);
      chk("R3", n, h, "low stretch");
    end

    // R6: illegal code stays silent while enabled
    bus_write(2'd0, 8'h00);
    repeat (140) @(negedge clk);
    bus_write(2'd0, 8'h3F);
    hi_seen = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (tone_o) hi_seen = 1;
    end
    chk("R6", hi_seen, 0, "output with code 0x1F");
    bus_read(2'd0, rd);
    chk("R2", rd, 8'h3F, "readback of illegal code");

    // R7: write captured on the terminal-count edge
    bus_write(2'd0, 8'h00);
    repeat (10) @(negedge clk);
    bus_write(2'd0, 8'hA6);           // select 10, code 6: half-period 8
    stretch(1'b0, n);                 // now just after a rising edge
    repeat (7) @(negedge clk);
    bus_write(2'd0, 8'hAE);           // code 14: half-period 16
    stretch(1'b0, n);
    chk("R7", n, 8, "low stretch after coinciding write");
    stretch(1'b1, n);
    chk("R7", n, 16, "first stretch at new setting");
    stretch(1'b0, n);
    chk("R7", n, 16, "second stretch at new setting");

    // R8: disable while running
    bus_write(2'd0, 8'h8E);
    repeat (20) @(negedge clk);
    chk("R8", tone_o, 0, "low after running disable");
    hi_seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tone_o) hi_seen = 1;
    end
    chk("R8", hi_seen, 0, "stays low after disable");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule